// File: doc/BRIEF.md
# Set-Associative Tag Directory Hit Monitor

This block watches a stream of memory addresses and measures how well a set-associative cache of a given geometry would serve it. It holds only the tag of each line, a valid bit per line and an age per line. No data, write policy or backing store is modelled. Each address presented with its strobe is split into a set index and a tag. The tags of that set are compared, the result is reported as hit or miss, and the set's replacement state is updated. On a miss the new tag takes over a line of that set.

Two running counters are exposed: accesses seen and hits seen. Their ratio is the hit rate of the trace. The counters can be zeroed at any time without disturbing the directory, so a trace can be measured after a warm-up phase. Default geometry: 4 ways, 16 sets, 16-byte lines and a 32-bit byte address.

Top module: `cache_hit_monitor`

## Requirements
- R1: The address splits into a line offset in bits [3:0], which is ignored, a set index in bits [7:4], and a tag in bits [31:8]. Sets are fully independent of one another.
- R2: `hit_valid` is high in the cycle after each cycle with `acc_valid` high, and low otherwise. `hit_flag` is only high while `hit_valid` is high.
- R3: An access is a hit when a valid line of its set holds its tag. A hit changes no tag and no valid bit.
- R4: On a miss in a set that still has invalid lines, the lowest-numbered invalid way receives the tag and becomes valid.
- R5: On a miss in a fully valid set, the least recently used way is replaced.
- R6: Recency is updated on every access, hit or miss. The accessed way becomes the most recent, and the relative order of the other ways is kept.
- R7: `access_count` increases by one for each access, and `hit_count` increases by one for each hit. Both new values are visible in the same cycle as the matching `hit_valid`.
- R8: Both counters saturate at their all-ones value.
- R9: `stats_clear` zeroes both counters at the next edge and takes priority over an access in the same cycle. It leaves the directory untouched; that access still looks up and updates the directory.
- R10: Reset invalidates every line, zeroes both counters and drives `hit_valid` and `hit_flag` low.
- R11: One access is accepted per cycle. Back-to-back accesses to the same set see the result of the previous access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W (32) | Byte address of the access |
| stats_clear | input | 1 | Zero both counters |
| hit_valid | output | 1 | Result of the previous cycle's access is on `hit_flag` |
| hit_flag | output | 1 | Previous access was a hit |
| access_count | output | CNT_W (32) | Saturating count of accesses |
| hit_count | output | CNT_W (32) | Saturating count of hits |

## Verification
The hardest condition to reach from the ports is a replacement decision that depends on earlier hits. A wrong victim only shows up as a later unexpected miss, several accesses after the mistake. The stimulus therefore fills one set, touches the oldest line so that it becomes the newest, and then interleaves misses and hits. Each victim choice is then checked by a re-access to the line that should have survived or should have been evicted. Saturation cannot be reached with 32-bit counters in a short run, so a second instance with 4-bit counters is driven past its limit.

// File: rtl/cmon_pkg.sv
package cmon_pkg;
  localparam int DEF_ADDR_W     = 32;
  localparam int DEF_WAYS       = 4;
  localparam int DEF_SETS       = 16;
  localparam int DEF_LINE_BYTES = 16;
  localparam int DEF_CNT_W      = 32;
endpackage

// File: rtl/cmon_lookup.sv
module cmon_lookup #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 24,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
  input  logic [WAYS-1:0]            way_vld,
  input  logic [TAG_W-1:0]           req_tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = way_vld[w] && (way_tags[w] == req_tag);
  end

  assign hit = |match;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) hit_way = hit_way | WAY_W'(w);
    end
  end
endmodule

// File: rtl/cmon_age_update.sv
module cmon_age_update #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][WAY_W-1:0] way_age,
  input  logic [WAYS-1:0]            way_vld,
  input  logic                       hit,
  input  logic [WAY_W-1:0]           hit_way,
  output logic [WAY_W-1:0]           touch_way,
  output logic [WAYS-1:0][WAY_W-1:0] age_nxt
);
  logic             any_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] oldest_way;
  logic [WAY_W-1:0] touch_age;

  // victim choice: lowest free way, else the oldest way
  always_comb begin
    any_free   = 1'b0;
    free_way   = '0;
    oldest_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_vld[w]) begin
        any_free = 1'b1;
        free_way = WAY_W'(w);
      end
      if (way_age[w] == WAY_W'(WAYS - 1)) oldest_way = WAY_W'(w);
    end
  end

  assign touch_way = hit ? hit_way : (any_free ? free_way : oldest_way);
  assign touch_age = way_age[touch_way];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == touch_way)   age_nxt[w] = '0;
      else if (way_age[w] < touch_age) age_nxt[w] = way_age[w] + 1'b1;
      else                          age_nxt[w] = way_age[w];
    end
  end
endmodule

// File: rtl/cmon_sat_counter.sv
module cmon_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             count_en;

  assign count_en = clr | inc;

  always_comb begin
    if (clr)                     count_d = '0;
    else if (count_q != '1)      count_d = count_q + 1'b1;
    else                         count_d = count_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/cache_hit_monitor.sv
module cache_hit_monitor
  import cmon_pkg::*;
#(
  parameter int ADDR_W     = DEF_ADDR_W,
  parameter int WAYS       = DEF_WAYS,
  parameter int SETS       = DEF_SETS,
  parameter int LINE_BYTES = DEF_LINE_BYTES,
  parameter int CNT_W      = DEF_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              stats_clear,
  output logic              hit_valid,
  output logic              hit_flag,
  output logic [CNT_W-1:0]  access_count,
  output logic [CNT_W-1:0]  hit_count
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // directory state
  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  logic [WAYS-1:0]            vld_q [SETS];
  logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];

  logic [IDX_W-1:0]           idx;
  logic [TAG_W-1:0]           req_tag;
  logic [WAYS-1:0][TAG_W-1:0] set_tags, tags_nxt;
  logic [WAYS-1:0]            set_vld, vld_nxt;
  logic [WAYS-1:0][WAY_W-1:0] set_age, age_nxt;
  logic                       lk_hit;
  logic [WAY_W-1:0]           lk_way, touch_way;
  logic                       hit_valid_q, hit_flag_q;

  assign idx      = acc_addr[OFF_W +: IDX_W];
  assign req_tag  = acc_addr[ADDR_W-1 -: TAG_W];
  assign set_tags = tag_q[idx];
  assign set_vld  = vld_q[idx];
  assign set_age  = age_q[idx];

  cmon_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
    .way_tags (set_tags),
    .way_vld  (set_vld),
    .req_tag  (req_tag),
    .hit      (lk_hit),
    .hit_way  (lk_way)
  );

  cmon_age_update #(.WAYS(WAYS)) u_age (
    .way_age   (set_age),
    .way_vld   (set_vld),
    .hit       (lk_hit),
    .hit_way   (lk_way),
    .touch_way (touch_way),
    .age_nxt   (age_nxt)
  );

  always_comb begin
    tags_nxt = set_tags;
    vld_nxt  = set_vld;
    if (!lk_hit) tags_nxt[touch_way] = req_tag;
    vld_nxt[touch_way] = 1'b1;
  end

  // tags need no reset: valid bits qualify them
  always_ff @(posedge clk) begin
    if (acc_valid) tag_q[idx] <= tags_nxt;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else if (acc_valid) begin
      vld_q[idx] <= vld_nxt;
      age_q[idx] <= age_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hit_valid_q <= 1'b0;
      hit_flag_q  <= 1'b0;
    end else begin
      hit_valid_q <= acc_valid;
      hit_flag_q  <= acc_valid & lk_hit;
    end
  end

  assign hit_valid = hit_valid_q;
  assign hit_flag  = hit_flag_q;

  cmon_sat_counter #(.CNT_W(CNT_W)) u_acc_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (stats_clear),
    .inc   (acc_valid),
    .count (access_count)
  );

  cmon_sat_counter #(.CNT_W(CNT_W)) u_hit_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (stats_clear),
    .inc   (acc_valid & lk_hit),
    .count (hit_count)
  );
endmodule

// File: rtl/cmon_chk.sv
module cmon_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             stats_clear,
  input logic             hit_valid,
  input logic             hit_flag,
  input logic [CNT_W-1:0] access_count,
  input logic [CNT_W-1:0] hit_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2
  result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> hit_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!hit_valid && !hit_flag));

  // R2
  flag_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_flag |-> hit_valid);

  // R7
  access_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !stats_clear && access_count != CNT_MAX)
      |=> access_count == $past(access_count) + 1'b1);

  // R7
  hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !stats_clear && hit_count != CNT_MAX)
      |=> hit_count == $past(hit_count) + CNT_W'(hit_flag));

  // R7
  hits_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_count <= access_count);

  // R8
  saturate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stats_clear && access_count == CNT_MAX) |=> access_count == CNT_MAX);

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stats_clear |=> (access_count == '0 && hit_count == '0));
endmodule

bind cache_hit_monitor cmon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .acc_valid    (acc_valid),
  .stats_clear  (stats_clear),
  .hit_valid    (hit_valid),
  .hit_flag     (hit_flag),
  .access_count (access_count),
  .hit_count    (hit_count)
);

// File: tb/tb_cache_hit_monitor.sv
`timescale 1ns/1ps
module tb_cache_hit_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        stats_clear = 1'b0;
  logic        hit_valid, hit_flag;
  logic [31:0] access_count, hit_count;
  logic        s_hit_valid, s_hit_flag;
  logic [3:0]  s_access_count, s_hit_count;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  cache_hit_monitor dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .stats_clear(stats_clear), .hit_valid(hit_valid), .hit_flag(hit_flag),
    .access_count(access_count), .hit_count(hit_count)
  );

  cache_hit_monitor #(.CNT_W(4)) dut_small (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .stats_clear(stats_clear), .hit_valid(s_hit_valid), .hit_flag(s_hit_flag),
    .access_count(s_access_count), .hit_count(s_hit_count)
  );

  // {address, expected hit}; set 0 unless noted, tag = addr[31:8]
  localparam int NV = 17;
  localparam logic [32:0] VECS [NV] = '{
    {32'h0000_0100, 1'b0},  // A fills a free way (R4)
    {32'h0000_0200, 1'b0},  // B
    {32'h0000_0304, 1'b0},  // C
    {32'h0000_040C, 1'b0},  // D, set now full
    {32'h0000_010F, 1'b1},  // A again, other offset (R1, R3, R6)
    {32'h0000_0500, 1'b0},  // E evicts B, not A (R5, R6)
    {32'h0000_0208, 1'b0},  // B evicts C
    {32'h0000_0400, 1'b1},  // D kept
    {32'h0000_0300, 1'b0},  // C evicts A
    {32'h0000_0100, 1'b0},  // A evicts E
    {32'h0000_040F, 1'b1},  // D
    {32'h0000_0201, 1'b1},  // B
    {32'h0000_0150, 1'b0},  // A in set 5: independent (R1)
    {32'h0000_015C, 1'b1},  // set 5 hit
    {32'h0000_0500, 1'b0},  // E evicted earlier, now evicts C
    {32'h8000_0100, 1'b0},  // differs from A only in tag msb
    {32'h0000_0100, 1'b0}   // A was the victim of the previous miss
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 hit_valid", {31'b0, hit_valid}, 32'd0);
    check("R10 access_count", access_count, 32'd0);
    check("R10 hit_count", hit_count, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk, one access per cycle (R11)
    for (int i = 0; i <= NV; i++) begin
      if (i > 0) begin
        check($sformatf("R2 hit_valid v%0d", i-1), {31'b0, hit_valid}, 32'd1);
        check($sformatf("R3/R5 hit_flag v%0d", i-1), {31'b0, hit_flag},
              {31'b0, VECS[i-1][0]});
      end
      if (i < NV) begin
        acc_valid = 1'b1;
        acc_addr  = VECS[i][32:1];
      end else begin
        acc_valid = 1'b0;
      end
      @(negedge clk);
    end
    // last iteration's wait covered the idle cycle
    check("R2 idle hit_valid", {31'b0, hit_valid}, 32'd0);
    check("R7 access_count", access_count, 32'd17);
    check("R7 hit_count", hit_count, 32'd5);

    // R9 clear alone keeps the directory
    stats_clear = 1'b1;
    @(negedge clk);
    stats_clear = 1'b0;
    check("R9 clear access", access_count, 32'd0);
    check("R9 clear hit", hit_count, 32'd0);
    acc_valid = 1'b1; acc_addr = 32'h0000_0100;
    @(negedge clk);
    acc_valid = 1'b0;
    check("R9 directory kept", {31'b0, hit_flag}, 32'd1);
    check("R7 counts after clear", access_count, 32'd1);

    // R9 clear wins over a same-cycle access
    acc_valid = 1'b1; stats_clear = 1'b1; acc_addr = 32'h0000_0100;
    @(negedge clk);
    acc_valid = 1'b0; stats_clear = 1'b0;
    check("R9 same-cycle hit_flag", {31'b0, hit_flag}, 32'd1);
    check("R9 same-cycle access", access_count, 32'd0);
    check("R9 same-cycle hit", hit_count, 32'd0);

    // R10 reset mid-run invalidates lines
    rst_n = 1'b0;
    #1;
    check("R10 async hit_valid", {31'b0, hit_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    acc_valid = 1'b1; acc_addr = 32'h0000_0100;
    @(negedge clk);
    acc_valid = 1'b0;
    check("R10 line invalidated", {31'b0, hit_flag}, 32'd0);
    check("R10 hit_valid after reset", {31'b0, hit_valid}, 32'd1);

    // R8 saturation on the narrow instance
    stats_clear = 1'b1;
    @(negedge clk);
    stats_clear = 1'b0;
    for (int k = 0; k < 20; k++) begin
      acc_valid = 1'b1; acc_addr = 32'h0000_0770;
      @(negedge clk);
    end
    acc_valid = 1'b0;
    @(negedge clk);
    check("R8 wide access", access_count, 32'd20);
    check("R8 wide hit", hit_count, 32'd19);
    check("R8 narrow access", {28'b0, s_access_count}, 32'd15);
    check("R8 narrow hit", {28'b0, s_hit_count}, 32'd15);

    finish_run();
  end
endmodule